// File: doc/BRIEF.md
# Per-Line Configurable Interrupt Detector

This block watches a vector of already-synchronised input lines and decides, line by line, whether each one is requesting an interrupt. Every line carries its own three configuration bits: a sense select that picks level or edge detection, a dual-edge select, and a polarity select. Together they give five useful behaviours: active-high level, active-low level, rising edge, falling edge and any edge. A per-line enable vector masks the result, and all masked lines are merged into one registered interrupt request.

Edge-detected events are held in a sticky status bit until software pulses the matching bit of the clear vector. Level-detected events are never held: the status bit simply mirrors whether the line currently sits at its active level, so the request disappears as soon as the source lets go. Register decoding, input synchronisers and pad logic sit outside the block; the configuration, enable and clear vectors arrive as plain inputs.

Top module: `pin_irq_detector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, with all lines low and edge sensing selected, the raw status is all zeros and irq_o is low.
- R2: With sense bit 1 a line is level sensitive: its raw bit is 1 exactly while the line equals its polarity bit (1 = active high, 0 = active low), combinationally, with no cycle of delay.
- R3: A level-sensitive raw bit returns to 0 as soon as the line leaves its active level, with no clear pulse.
- R4: With sense 0 and dual-edge 0, polarity 1 latches a status bit on a 0-to-1 transition and polarity 0 on a 1-to-0 transition; the opposite transition sets nothing. The raw bit rises on the clock edge that first samples the new line value.
- R5: With sense 0 and dual-edge 1, either transition latches the status bit, whatever the polarity bit holds.
- R6: An edge-latched status bit stays 1 while its clear bit is 0 and drops to 0 on the clock edge where its clear bit is 1.
- R7: When a qualifying edge and a clear for the same line fall in the same cycle, the status bit is 1 after that clock edge.
- R8: masked_o equals raw_o ANDed bitwise with enable_i, combinationally.
- R9: irq_o is the OR of all masked_o bits as they stood before the previous clock edge (one register of delay).
- R10: The previous-value register of every line samples the line on every clock edge, whatever its configuration, so switching a line from level to edge sensing while the line holds steady latches no status.
- R11: While a line is level sensitive its edge latch is held at 0, so an event latched earlier does not reappear when the line is returned to edge sensing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | LINES | Synchronised input lines |
| sense_i | input | LINES | 1 = level sensitive, 0 = edge sensitive |
| both_i | input | LINES | 1 = any edge (edge mode only) |
| event_i | input | LINES | Polarity: high/rising when 1, low/falling when 0 |
| enable_i | input | LINES | Per-line interrupt enable |
| clear_i | input | LINES | Clear strobe for edge-latched status, 1 clears |
| raw_o | output | LINES | Status before masking |
| masked_o | output | LINES | Status after enable masking |
| irq_o | output | 1 | Registered OR of masked status |

## Verification
The interesting collision is an edge arriving on a line in the very cycle its clear bit is pulsed; the two compete for the same sticky bit. The bench forces it directly, once on a line whose bit is already set and once on a clear bit, and also lets random sparse clears land on random line toggles thousands of times. A cycle-accurate bench model that gives the new edge priority judges every outcome, so a design that lets the clear win is reported on the first collision.

// File: rtl/irqdet_pkg.sv
package irqdet_pkg;

  typedef struct packed {
    logic sense;  // 1: level, 0: edge
    logic both;   // any edge in edge mode
    logic pol;    // high/rising when 1
  } line_cfg_t;

  function automatic logic edge_qualifies(line_cfg_t cfg, logic rise, logic fall);
    logic pick;
    pick = cfg.pol ? rise : fall;
    return !cfg.sense && (cfg.both ? (rise || fall) : pick);
  endfunction

endpackage

// File: rtl/irqdet_line.sv
module irqdet_line
  import irqdet_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  line_cfg_t cfg_i,
  input  logic      clear_i,
  output logic      raw_o
);

  logic prev_q;
  logic latch_q;
  logic latch_d;
  logic latch_en;
  logic rise;
  logic fall;
  logic hit;
  logic level_hit;

  always_comb begin
    rise      = pin_i & ~prev_q;
    fall      = ~pin_i & prev_q;
    hit       = edge_qualifies(cfg_i, rise, fall);
    level_hit = ~(pin_i ^ cfg_i.pol);
    // a fresh edge outranks a clear; level mode keeps the latch empty
    latch_en  = cfg_i.sense | hit | clear_i;
    latch_d   = hit;
    raw_o     = cfg_i.sense ? level_hit : latch_q;
  end

  // previous value tracks the line every cycle regardless of mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (latch_en) latch_q <= latch_d;
  end

endmodule

// File: rtl/irqdet_merge.sv
module irqdet_merge #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  input  logic [LINES-1:0] enable_i,
  output logic [LINES-1:0] masked_o,
  output logic             irq_o
);

  logic irq_d;
  logic irq_q;

  always_comb begin
    masked_o = raw_i & enable_i;
    irq_d    = |masked_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
  import irqdet_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pins_i,
  input  logic [LINES-1:0] sense_i,
  input  logic [LINES-1:0] both_i,
  input  logic [LINES-1:0] event_i,
  input  logic [LINES-1:0] enable_i,
  input  logic [LINES-1:0] clear_i,
  output logic [LINES-1:0] raw_o,
  output logic [LINES-1:0] masked_o,
  output logic             irq_o
);

  line_cfg_t cfg [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign cfg[g] = '{sense: sense_i[g], both: both_i[g], pol: event_i[g]};

    irqdet_line u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pins_i[g]),
      .cfg_i   (cfg[g]),
      .clear_i (clear_i[g]),
      .raw_o   (raw_o[g])
    );
  end

  irqdet_merge #(.LINES(LINES)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_i    (raw_o),
    .enable_i (enable_i),
    .masked_o (masked_o),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/irqdet_checker.sv
module irqdet_checker #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] pins_i,
  input logic [LINES-1:0] sense_i,
  input logic [LINES-1:0] event_i,
  input logic [LINES-1:0] enable_i,
  input logic [LINES-1:0] clear_i,
  input logic [LINES-1:0] raw_o,
  input logic [LINES-1:0] masked_o,
  input logic             irq_o
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_LEVEL_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_o ^ ~(pins_i ^ event_i)) & sense_i) == '0); // R2

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    ($past(raw_o & ~sense_i & ~clear_i) & ~sense_i & ~raw_o) == '0); // R6

  AST_MASK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    masked_o == (raw_o & enable_i)); // R8

  AST_IRQ_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    irq_o == (|$past(masked_o))); // R9

endmodule

bind pin_irq_detector irqdet_checker #(.LINES(LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pins_i   (pins_i),
  .sense_i  (sense_i),
  .event_i  (event_i),
  .enable_i (enable_i),
  .clear_i  (clear_i),
  .raw_o    (raw_o),
  .masked_o (masked_o),
  .irq_o    (irq_o)
);

// File: tb/pin_irq_detector_tb.sv
module pin_irq_detector_tb;

  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] pins, sense, both, evt, en, clr;
  logic [N-1:0] raw_o, masked_o;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [N-1:0] m_prev, m_stat;
  logic         m_irq;

  pin_irq_detector #(.LINES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .sense_i(sense), .both_i(both),
    .event_i(evt), .enable_i(en), .clear_i(clr),
    .raw_o(raw_o), .masked_o(masked_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [N-1:0] exp_raw(logic [N-1:0] stat);
    return (sense & ~(pins ^ evt)) | (~sense & stat);
  endfunction

  function automatic logic [N-1:0] exp_hit();
    logic [N-1:0] rise, fall;
    rise = ~m_prev & pins;
    fall = m_prev & ~pins;
    return ~sense & ((both & (rise | fall)) | (~both & evt & rise) | (~both & ~evt & fall));
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one clock: model advances at the edge, outputs compared 1 ns later
  task automatic step();
    logic [N-1:0] rpre;
    @(posedge clk);
    rpre   = exp_raw(m_stat);
    m_irq  = |(rpre & en);
    m_stat = ~sense & (exp_hit() | (m_stat & ~clr));
    m_prev = pins;
    #1;
    chk("R2", raw_o & sense, exp_raw(m_stat) & sense);
    chk("R6", raw_o & ~sense, m_stat & ~sense);
    chk("R8", masked_o, exp_raw(m_stat) & en);
    chk("R9", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, m_irq});
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; pins = '0; sense = '0; both = '0; evt = '0; en = '0; clr = '0;
    m_prev = '0; m_stat = '0; m_irq = 0;
    repeat (3) @(negedge clk);
    chk("R1", raw_o, '0);
    chk("R1", {{(N-1){1'b0}}, irq_o}, '0);
    rst_n = 1;
    step();
    chk("R1", raw_o, '0);

    // rising edge on line 0, falling ignored
    en = 8'h01; evt[0] = 1;
    pins[0] = 1; step(); chk("R4", raw_o[0], 1);
    step(); chk("R9", irq_o, 1);
    clr[0] = 1; step(); clr[0] = 0; chk("R6", raw_o[0], 0);
    step(); chk("R6", raw_o[0], 0);
    pins[0] = 0; step(); chk("R4", raw_o[0], 0);
    // falling polarity on line 1
    pins[1] = 1; step(); chk("R4", raw_o[1], 0);
    pins[1] = 0; step(); chk("R4", raw_o[1], 1);
    repeat (3) step(); chk("R6", raw_o[1], 1);
    clr[1] = 1; step(); clr[1] = 0; chk("R6", raw_o[1], 0);

    // any edge on line 2, polarity ignored
    both[2] = 1; evt[2] = 0;
    pins[2] = 1; step(); chk("R5", raw_o[2], 1);
    clr[2] = 1; step(); clr[2] = 0; chk("R5", raw_o[2], 0);
    pins[2] = 0; step(); chk("R5", raw_o[2], 1);

    // edge and clear together: edge wins, on set and on cleared bit
    pins[2] = 1; clr[2] = 1; step(); clr[2] = 0; chk("R7", raw_o[2], 1);
    clr[2] = 1; step(); clr[2] = 0; chk("R7", raw_o[2], 0);
    pins[2] = 0; clr[2] = 1; step(); clr[2] = 0; chk("R7", raw_o[2], 1);
    clr[2] = 1; step(); clr[2] = 0;

    // level modes on line 3 (high) and line 4 (low)
    sense[3] = 1; evt[3] = 1; sense[4] = 1; evt[4] = 0; en = 8'h18;
    #1; chk("R2", raw_o[4:3], 2'b10);
    pins[3] = 1; pins[4] = 1; #1; chk("R2", raw_o[4:3], 2'b01);
    step(); chk("R3", raw_o[4:3], 2'b01);
    pins[3] = 0; #1; chk("R3", raw_o[3], 0);
    step(); chk("R3", raw_o[3], 0);

    // level -> edge switch with steady high line: no false edge
    pins[5] = 1; sense[5] = 1; evt[5] = 1; step(); step();
    sense[5] = 0; both[5] = 1; step(); chk("R10", raw_o[5], 0);

    // latched edge is dropped while in level mode
    pins[6] = 1; evt[6] = 1; step(); chk("R11", raw_o[6], 1);
    sense[6] = 1; evt[6] = 0; step(); chk("R11", raw_o[6], 0);
    sense[6] = 0; evt[6] = 1; step(); chk("R11", raw_o[6], 0);

    // random phase with sparse clears
    for (int i = 0; i < 4000; i++) begin
      pins  = pins ^ (N'($urandom) & N'($urandom));
      if ((i % 97) == 0) begin
        sense = N'($urandom); both = N'($urandom); evt = N'($urandom);
      end
      en    = ((i % 13) == 0) ? N'($urandom) : en;
      clr   = N'($urandom) & N'($urandom) & N'($urandom);
      step();
    end
    clr = '0;
    finish_run();
  end

endmodule